// File: doc/BRIEF.md
# Operating Point Table Discovery Sequencer

This block learns which clock frequencies a power-management coprocessor can run the CPU cluster at. It sits above a mailbox command issuer. It drives single-beat requests (command byte plus argument word 0) and reads two coprocessor registers through a simple register-read port. On a start pulse it goes through a fixed order of steps. First it confirms that the expected firmware is present. It then saves the running performance state and steps the coprocessor through every state in ascending order. After each step it reads the resulting frequency, converts it from MHz to kHz and stores it. It then puts back the saved state, enables scaling and reports the frequency of the state now in force.

Any step that fails stops the run at once. The run ends with a one-cycle done pulse that carries an error code. The five table entries hold a frequency and a state index. They are flagged valid only after a run in which every step succeeded.

Top module: `optbl_seq`

## Requirements
- R1: The first action after an accepted start is a register read at address 0x34. If the value read differs from 0xA11600D1, the run ends with err_code 8 and issues no command.
- R2: The second action is command 0x30. If its response code is 1 (invalid) or 2 (unsupported), the run ends with that code. Any other code, including a nonzero one, lets the run continue.
- R3: The next command is 0x40. Its returned argument word is kept as the saved state.
- R4: For each state i from 0 to 4 in ascending order, the block issues command 0x41 with argument i. After each such command succeeds, it reads register address 0x50.
- R5: Table entry i holds the value read from 0x50 after state i multiplied by 1000, modulo 2^32, in bits [32*i+31:32*i] of tbl_freq. The state index i sits in bits [3*i+2:3*i] of tbl_idx.
- R6: After the sweep, command 0x41 is issued with the saved state as its argument.
- R7: Command 0x11 with argument 0 follows, then command 0x40. cur_freq becomes the table frequency of the state that command returns. A returned state of 5 or more ends the run with err_code 9.
- R8: A nonzero response code at any command step other than 0x30 ends the run with that code, and no further request or read is issued.
- R9: tbl_valid clears when a start is accepted. It rises only together with a done pulse whose err_code is 0.
- R10: done is a one-cycle pulse, exactly one per accepted start. busy is high from the cycle after an accepted start until done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a discovery run (ignored while busy) |
| req_valid | output | 1 | One-cycle command request pulse to the issuer |
| req_cmd | output | 8 | Command byte |
| req_arg | output | 32 | Argument word 0 |
| rsp_valid | input | 1 | Command response strobe |
| rsp_code | input | 4 | Response code, 0 = success, 1 = invalid, 2 = unsupported |
| rsp_arg | input | 32 | Returned argument word 0 |
| rd_en | output | 1 | One-cycle register read request |
| rd_addr | output | 8 | Register byte address |
| rd_valid | input | 1 | Read data strobe |
| rd_data | input | 32 | Read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 4 | Result of last run, 0 = success |
| tbl_valid | output | 1 | Table and cur_freq hold a complete run |
| tbl_freq | output | 160 | Five frequencies in kHz, entry i at bits 32*i |
| tbl_idx | output | 15 | Five state indices, entry i at bits 3*i |
| cur_freq | output | 32 | Frequency in kHz of the state in force |

## Verification
Each request or read pulse leaves the block one cycle after the response that came before it. So the order of all transactions is logged at the edge where the pulse is seen, and compared against an expected list computed from the run's configuration. done, err_code, tbl_valid, the table and cur_freq all change at the edge that takes in the final response. The bench waits for done and reads them at the falling edge of that same cycle. It then checks one cycle later that done has dropped, and a few cycles later that no stray transaction followed. Runs sweep every initial state under response latencies of 0 to 2 cycles, inject a failure at every command step, and cover the identity and range aborts.

// File: rtl/optbl_seq.sv
module optbl_seq #(
  parameter int          NSTATE    = 5,
  parameter int          DW        = 32,
  parameter int          AW        = 8,
  parameter int          CW        = 4,
  parameter logic [7:0]  CMD_GMAP  = 8'h30,
  parameter logic [7:0]  CMD_GST   = 8'h40,
  parameter logic [7:0]  CMD_SST   = 8'h41,
  parameter logic [7:0]  CMD_EN    = 8'h11,
  parameter logic [AW-1:0] ID_ADDR = 8'h34,
  parameter logic [AW-1:0] FQ_ADDR = 8'h50,
  parameter logic [DW-1:0] ID_VAL  = 32'hA11600D1,
  parameter logic [CW-1:0] RC_INV  = 4'd1,
  parameter logic [CW-1:0] RC_UNS  = 4'd2,
  parameter logic [CW-1:0] E_IDENT = 4'd8,
  parameter logic [CW-1:0] E_RANGE = 4'd9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  output logic                 req_valid,
  output logic [7:0]           req_cmd,
  output logic [DW-1:0]        req_arg,
  input  logic                 rsp_valid,
  input  logic [CW-1:0]        rsp_code,
  input  logic [DW-1:0]        rsp_arg,
  output logic                 rd_en,
  output logic [AW-1:0]        rd_addr,
  input  logic                 rd_valid,
  input  logic [DW-1:0]        rd_data,
  output logic                 busy,
  output logic                 done,
  output logic [CW-1:0]        err_code,
  output logic                 tbl_valid,
  output logic [NSTATE*DW-1:0] tbl_freq,
  output logic [NSTATE*$clog2(NSTATE)-1:0] tbl_idx,
  output logic [DW-1:0]        cur_freq
);
  localparam int SW = $clog2(NSTATE);
  localparam logic [SW-1:0] LAST = SW'(NSTATE - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_MAGIC, S_PROBE, S_SAVE, S_SET, S_FREQ, S_RESTORE, S_ENABLE, S_CUR
  } st_t;

  st_t            st;
  logic           launched;
  logic [SW-1:0]  idx;
  logic [DW-1:0]  saved;
  logic [DW-1:0]  ent_f [NSTATE];
  logic [SW-1:0]  ent_i [NSTATE];

  wire is_cmd = (st == S_PROBE) || (st == S_SAVE) || (st == S_SET) ||
                (st == S_RESTORE) || (st == S_ENABLE) || (st == S_CUR);
  wire is_rd  = (st == S_MAGIC) || (st == S_FREQ);

  assign busy      = (st != S_IDLE);
  assign req_valid = is_cmd && !launched;
  assign rd_en     = is_rd && !launched;
  assign rd_addr   = (st == S_MAGIC) ? ID_ADDR : FQ_ADDR;

  always_comb begin
    req_cmd = CMD_GST;
    req_arg = '0;
    case (st)
      S_PROBE:   req_cmd = CMD_GMAP;
      S_SET:     begin req_cmd = CMD_SST; req_arg = {{(DW-SW){1'b0}}, idx}; end
      S_RESTORE: begin req_cmd = CMD_SST; req_arg = saved; end
      S_ENABLE:  req_cmd = CMD_EN;
      default:   req_cmd = CMD_GST;
    endcase
  end

  wire [DW-1:0] khz = (rd_data << 10) - (rd_data << 4) - (rd_data << 3);

  genvar g;
  generate
    for (g = 0; g < NSTATE; g++) begin : g_out
      assign tbl_freq[g*DW +: DW] = ent_f[g];
      assign tbl_idx[g*SW +: SW]  = ent_i[g];
    end
  endgenerate

  wire got_rsp = is_cmd && launched && rsp_valid;
  wire got_rd  = is_rd && launched && rd_valid;
  wire rsp_bad = (rsp_code != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      launched  <= 1'b0;
      idx       <= '0;
      saved     <= '0;
      done      <= 1'b0;
      err_code  <= '0;
      tbl_valid <= 1'b0;
      cur_freq  <= '0;
      for (int i = 0; i < NSTATE; i++) begin
        ent_f[i] <= '0;
        ent_i[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (req_valid || rd_en) launched <= 1'b1;
      if (got_rsp || got_rd)  launched <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st        <= S_MAGIC;
          launched  <= 1'b0;
          err_code  <= '0;
          tbl_valid <= 1'b0;
          cur_freq  <= '0;
        end
        S_MAGIC: if (got_rd) begin
          if (rd_data == ID_VAL) st <= S_PROBE;
          else begin st <= S_IDLE; done <= 1'b1; err_code <= E_IDENT; end
        end
        S_PROBE: if (got_rsp) begin
          if (rsp_code == RC_INV || rsp_code == RC_UNS) begin
            st <= S_IDLE; done <= 1'b1; err_code <= rsp_code;
          end else st <= S_SAVE;
        end
        S_SAVE: if (got_rsp) begin
          if (rsp_bad) begin st <= S_IDLE; done <= 1'b1; err_code <= rsp_code; end
          else begin saved <= rsp_arg; idx <= '0; st <= S_SET; end
        end
        S_SET: if (got_rsp) begin
          if (rsp_bad) begin st <= S_IDLE; done <= 1'b1; err_code <= rsp_code; end
          else st <= S_FREQ;
        end
        S_FREQ: if (got_rd) begin
          ent_f[idx] <= khz;
          ent_i[idx] <= idx;
          if (idx == LAST) st <= S_RESTORE;
          else begin idx <= idx + 1'b1; st <= S_SET; end
        end
        S_RESTORE: if (got_rsp) begin
          if (rsp_bad) begin st <= S_IDLE; done <= 1'b1; err_code <= rsp_code; end
          else st <= S_ENABLE;
        end
        S_ENABLE: if (got_rsp) begin
          if (rsp_bad) begin st <= S_IDLE; done <= 1'b1; err_code <= rsp_code; end
          else st <= S_CUR;
        end
        S_CUR: if (got_rsp) begin
          st   <= S_IDLE;
          done <= 1'b1;
          if (rsp_bad) err_code <= rsp_code;
          else if (rsp_arg >= DW'(NSTATE)) err_code <= E_RANGE;
          else begin
            cur_freq  <= ent_f[rsp_arg[SW-1:0]];
            tbl_valid <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_IDENT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && st == S_MAGIC && launched && rd_data != ID_VAL) |=> (done && err_code == E_IDENT)); // R1
  AST_READ_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && launched && st == S_SET && rsp_code == '0) |=> (rd_en && rd_addr == FQ_ADDR)); // R4
  AST_STEP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && launched && is_cmd && st != S_PROBE && rsp_code != '0) |=> (done && !busy && !tbl_valid)); // R8
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !tbl_valid); // R9
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_valid) |-> (done && err_code == '0)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R10
endmodule

// File: tb/sim_optbl_seq.sv
module sim_optbl_seq;
  logic clk = 0, rst_n = 0, start = 0;
  always #2 clk = ~clk;

  logic req_valid, rsp_valid, rd_en, rd_valid, busy, done, tbl_valid;
  logic [7:0] req_cmd, rd_addr;
  logic [31:0] req_arg, rsp_arg, rd_data, cur_freq;
  logic [3:0] rsp_code, err_code;
  logic [159:0] tbl_freq;
  logic [14:0] tbl_idx;

  optbl_seq u0 (.clk, .rst_n, .start, .req_valid, .req_cmd, .req_arg,
    .rsp_valid, .rsp_code, .rsp_arg, .rd_en, .rd_addr, .rd_valid, .rd_data,
    .busy, .done, .err_code, .tbl_valid, .tbl_freq, .tbl_idx, .cur_freq);

  int nchk = 0, nfail = 0;
  int lat = 0, init_ps = 0, fail_step = -1, fail_code = 0;
  logic [31:0] magic_v = 32'hA11600D1;
  logic [31:0] fw [5];
  bit force_bad = 0;

  logic [47:0] lg [0:31];
  int logn, ncmd, ps;
  bit en_seen, c_pend, r_pend;
  int c_cnt, r_cnt;
  logic [7:0] c_cmd, r_addr;
  logic [31:0] c_arg;
  logic [3:0] c_code;

  always @(posedge clk) begin
    rsp_valid <= 0; rd_valid <= 0;
    if (!rst_n) begin
      logn <= 0; ncmd <= 0; c_pend <= 0; r_pend <= 0; rsp_code <= 0;
      rsp_arg <= 0; rd_data <= 0; ps <= 0; en_seen <= 0;
    end else begin
      if (start && !busy) begin
        logn <= 0; ncmd <= 0; ps <= init_ps; en_seen <= 0;
      end
      if (req_valid) begin
        if (logn < 32) lg[logn] <= {8'h00, req_cmd, req_arg};
        logn <= logn + 1; ncmd <= ncmd + 1;
        c_pend <= 1; c_cnt <= lat; c_cmd <= req_cmd; c_arg <= req_arg;
        c_code <= (ncmd == fail_step) ? 4'(fail_code) : 4'd0;
      end else if (c_pend) begin
        if (c_cnt == 0) begin
          c_pend <= 0; rsp_valid <= 1; rsp_code <= c_code; rsp_arg <= 0;
          if (c_code == 0 && c_cmd == 8'h41) ps <= int'(c_arg);
          if (c_code == 0 && c_cmd == 8'h11) en_seen <= 1;
          if (c_cmd == 8'h40) rsp_arg <= (force_bad && en_seen) ? 32'd7 : 32'(ps);
        end else c_cnt <= c_cnt - 1;
      end
      if (rd_en) begin
        if (logn < 32) lg[logn] <= {8'h01, rd_addr, 32'h0};
        logn <= logn + 1;
        r_pend <= 1; r_cnt <= lat; r_addr <= rd_addr;
      end else if (r_pend) begin
        if (r_cnt == 0) begin
          r_pend <= 0; rd_valid <= 1;
          rd_data <= (r_addr == 8'h34) ? magic_v :
                     (r_addr == 8'h50 && ps < 5) ? fw[ps] : 32'h0;
        end else r_cnt <= r_cnt - 1;
      end
    end
  end

  logic [47:0] ex [0:31];
  int exn, cmdk;
  bit stp;

  task automatic add_c(input logic [7:0] c, input logic [31:0] a);
    if (!stp) begin
      ex[exn] = {8'h00, c, a}; exn++;
      if (cmdk == fail_step && (cmdk != 0 || fail_code == 1 || fail_code == 2)) stp = 1;
      cmdk++;
    end
  endtask

  task automatic add_r(input logic [7:0] a);
    if (!stp) begin ex[exn] = {8'h01, a, 32'h0}; exn++; end
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic logic [31:0] khz(input logic [31:0] m);
    logic [63:0] p = 64'(m) * 64'd1000;
    return p[31:0];
  endfunction

  task automatic run(input bit mid_start);
    int cyc = 0, eerr;
    bool_ok: begin end
    exn = 0; cmdk = 0; stp = 0;
    add_r(8'h34);
    if (magic_v != 32'hA11600D1) stp = 1;
    add_c(8'h30, 0); add_c(8'h40, 0);
    for (int i = 0; i < 5; i++) begin add_c(8'h41, 32'(i)); add_r(8'h50); end
    add_c(8'h41, 32'(init_ps)); add_c(8'h11, 0); add_c(8'h40, 0);
    if (magic_v != 32'hA11600D1) eerr = 8;
    else if (fail_step >= 0 && (fail_step != 0 || fail_code == 1 || fail_code == 2)) eerr = fail_code;
    else if (force_bad) eerr = 9;
    else eerr = 0;

    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(busy == 1, "R10 busy after start", 64'(busy), 1);
    chk(tbl_valid == 0, "R9 valid cleared on start", 64'(tbl_valid), 0);
    while (!done && cyc < 3000) begin
      @(negedge clk); cyc++;
      if (mid_start && cyc == 10) start = 1; else start = 0;
    end
    start = 0;
    chk(done == 1, "R10 run ended (watchdog)", 64'(done), 1);
    chk(err_code == 4'(eerr), "R8 err_code", 64'(err_code), 64'(eerr));
    chk(tbl_valid == (eerr == 0), "R9 tbl_valid", 64'(tbl_valid), 64'(eerr == 0));
    if (eerr == 0) begin
      for (int i = 0; i < 5; i++) begin
        chk(tbl_freq[i*32 +: 32] == khz(fw[i]), "R5 entry freq", 64'(tbl_freq[i*32 +: 32]), 64'(khz(fw[i])));
        chk(tbl_idx[i*3 +: 3] == 3'(i), "R5 entry idx", 64'(tbl_idx[i*3 +: 3]), 64'(i));
      end
      chk(cur_freq == khz(fw[init_ps]), "R7 cur_freq", 64'(cur_freq), 64'(khz(fw[init_ps])));
      chk(ps == init_ps, "R6 state restored", 64'(ps), 64'(init_ps));
    end
    @(negedge clk);
    chk(done == 0 && busy == 0, "R10 done one cycle", 64'(done), 0);
    repeat (6) @(negedge clk);
    chk(logn == exn, "R8 transaction count", 64'(logn), 64'(exn));
    for (int i = 0; i < exn && i < logn; i++)
      chk(lg[i] == ex[i], (i == 0) ? "R1 first read" : (i < 3) ? "R2 R3 order" : "R4 R6 R7 order",
          64'(lg[i]), 64'(ex[i]));
  endtask

  task automatic cfg_default();
    lat = 0; init_ps = 0; fail_step = -1; fail_code = 0;
    magic_v = 32'hA11600D1; force_bad = 0;
    for (int i = 0; i < 5; i++) fw[i] = 32'(400 + 300 * i);
  endtask

  initial begin
    cfg_default();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !tbl_valid && !req_valid && !rd_en && err_code == 0,
        "R10 reset state", 64'({busy, done, tbl_valid, req_valid, rd_en}), 0);

    for (int l = 0; l < 3; l++)
      for (int s = 0; s < 5; s++) begin
        cfg_default(); lat = l; init_ps = s;
        for (int i = 0; i < 5; i++) fw[i] = 32'(100 * (s + 1) + 37 * i + l);
        run(0);
      end

    cfg_default(); init_ps = 3; fw[3] = 32'hFFFF_FFFF; fw[1] = 32'h0041_8938; run(0);
    cfg_default(); init_ps = 2; lat = 1; run(1);

    cfg_default(); magic_v = 32'hA11600D0; run(0);
    cfg_default(); fail_step = 0; fail_code = 1; run(0);
    cfg_default(); fail_step = 0; fail_code = 2; lat = 2; run(0);
    cfg_default(); fail_step = 0; fail_code = 3; init_ps = 4; run(0);
    cfg_default(); fail_step = 0; fail_code = 5; init_ps = 1; run(0);
    for (int k = 1; k < 10; k++) begin
      cfg_default(); init_ps = k % 5; fail_step = k; fail_code = (k % 2) ? 5 : 6; lat = k % 3;
      run(0);
    end
    cfg_default(); force_bad = 1; init_ps = 2; run(0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #4000000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule